// File: doc/BRIEF.md
# Calendar Shadow Read-Consistency Unit

This unit connects the battery-domain calendar counters to the bus-clock register file. It keeps bus-domain shadow copies of the subsecond, time and date words. A request/acknowledge toggle handshake refreshes them from the RTC clock domain. Each hand-off gathers all three words in one capture, so the words in a shadow set always come from the same instant. Each completed refresh raises an update-complete flag. Software clears the flag by reading any calendar word or by writing a zero to it.

Software reads the calendar as a multi-word transaction. A read of the subsecond word freezes the time and date shadows. A read of the time word freezes the date shadow. Reading the date word ends the transaction and releases the freeze. While the freeze is held, the unfrozen lower-order shadows keep refreshing, and the flag cannot be raised. A bypass control routes the live calendar words straight to the read data and holds the flag low.

Top module: `cal_shadow_unit`

## Requirements
- R1: In shadow mode (bypass_en=0), once the live words have been stable for long enough, subsec_data, time_data and date_data equal them. A new capture is started every RESYNC_DIV RTC clock cycles whenever no transfer is in flight.
- R2: Each refresh that completes while no freeze is held sets upd_flag to 1. With the flag cleared and no freeze, it sets again within a bounded number of bus cycles.
- R3: While rst_n is low, all three read data words and upd_flag are 0 (shadow mode).
- R4: A pulse on rd_subsec freezes the time and date shadows. A pulse on rd_time freezes the date shadow. Frozen shadows keep their value while the live words change, and the subsecond shadow keeps refreshing. The time freeze lasts across later rd_time pulses.
- R5: With bypass_en=1, the three read data words equal the live words in the same cycle. upd_flag is 0 from the first bus edge that samples bypass_en=1.
- R6: A pulse on any read strobe clears upd_flag on the next bus edge, unless a flag-setting refresh completes in the same cycle. In that case the set wins.
- R7: A pulse on flag_wr with flag_wdata=0 clears upd_flag. A pulse with flag_wdata=1 leaves upd_flag unchanged.
- R8: All fields of a shadow set come from a single capture. The captured word set stays stable in the RTC domain until its acknowledge returns.
- R9: upd_flag does not rise while any freeze is held. This includes the edge on which rd_subsec or rd_time establishes a freeze.
- R10: A pulse on rd_date releases both freezes, and rd_date takes priority over rd_subsec or rd_time pulsed in the same cycle. After the release, the frozen shadows pick up the live words again.
- R11: Read strobes given while bypass_en=1 establish no freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtc_clk | input | 1 | Calendar (RTC) domain clock |
| bus_clk | input | 1 | Register interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| live_subsec | input | SS_W | Live subsecond word from the calendar counters |
| live_time | input | TM_W | Live time word |
| live_date | input | DT_W | Live date word |
| rd_subsec | input | 1 | Read strobe for the subsecond word (one bus cycle) |
| rd_time | input | 1 | Read strobe for the time word |
| rd_date | input | 1 | Read strobe for the date word |
| bypass_en | input | 1 | 1 = return live words, 0 = return shadows |
| flag_wr | input | 1 | Write strobe for the update-complete flag |
| flag_wdata | input | 1 | Write data for the flag; only 0 has an effect |
| subsec_data | output | SS_W | Subsecond read data |
| time_data | output | TM_W | Time read data |
| date_data | output | DT_W | Date read data |
| upd_flag | output | 1 | Update-complete flag |

## Verification
The bench builds the unit with narrow words: SS_W=4, TM_W=6, DT_W=5 and RESYNC_DIV=2. A sweep over all sixteen subsecond codes fits in a short run, and each code drives time and date values derived arithmetically from it, which exposes any mixing of fields from different captures. The bench can stop the RTC clock, so it can check flag clearing by read and by write in windows where no refresh can race the check. The narrow words also let the bench pick freeze-test values that differ in every field, so a shadow that refreshed while frozen shows up as a changed value.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;

  typedef struct packed {
    logic time_lk;
    logic date_lk;
  } lock_t;

  // Freeze state after one bus cycle: date read releases and wins.
  function automatic lock_t lock_next(lock_t cur, logic rd_ss, logic rd_tm,
                                      logic rd_dt, logic byp);
    lock_t n;
    n = cur;
    if (rd_dt) begin
      n = '0;
    end else if (!byp) begin
      if (rd_ss) begin
        n.time_lk = 1'b1;
        n.date_lk = 1'b1;
      end
      if (rd_tm) begin
        n.date_lk = 1'b1;
      end
    end
    return n;
  endfunction

  // Flag after one bus cycle: bypass forces low, a quiet refresh wins over clears.
  function automatic logic flag_next(logic cur, logic byp, logic load,
                                     logic quiet, logic clr);
    logic n;
    if (byp)                n = 1'b0;
    else if (load && quiet) n = 1'b1;
    else if (clr)           n = 1'b0;
    else                    n = cur;
    return n;
  endfunction

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/cal_bit_sync.sv
module cal_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cal_rtc_side.sv
module cal_rtc_side #(
  parameter int HW  = 8,
  parameter int DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] live_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [HW-1:0] hold_o
);
  localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          req_n;
  logic [HW-1:0] hold_n;
  logic          tick, idle, cap;

  always_comb begin
    tick   = (cnt_q == LAST);
    idle   = (req_o == ack_i);
    cap    = tick && idle;
    cnt_n  = tick ? '0 : cnt_q + 1'b1;
    req_n  = ~req_o;
    hold_n = live_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      hold_o <= '0;
    end else if (cap) begin
      req_o  <= req_n;
      hold_o <= hold_n;
    end
  end
endmodule

// File: rtl/cal_bus_side.sv
module cal_bus_side
  import cal_shadow_pkg::*;
#(
  parameter int SS_W = 16,
  parameter int TM_W = 24,
  parameter int DT_W = 24,
  localparam int HW  = SS_W + TM_W + DT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [HW-1:0]   hold_i,
  input  logic            rd_ss_i,
  input  logic            rd_tm_i,
  input  logic            rd_dt_i,
  input  logic            bypass_i,
  input  logic            flag_wr_i,
  input  logic            flag_wdata_i,
  output logic            ack_o,
  output logic [SS_W-1:0] sh_ss_o,
  output logic [TM_W-1:0] sh_tm_o,
  output logic [DT_W-1:0] sh_dt_o,
  output logic            flag_o,
  output lock_t           lock_o,
  output logic            load_o
);
  lock_t lock_n;
  logic  flag_n, quiet, clr;
  logic  ld_tm, ld_dt;
  logic [SS_W-1:0] ss_n;
  logic [TM_W-1:0] tm_n;
  logic [DT_W-1:0] dt_n;

  always_comb begin
    load_o = req_i ^ ack_o;
    lock_n = lock_next(lock_o, rd_ss_i, rd_tm_i, rd_dt_i, bypass_i);
    quiet  = !(lock_n.time_lk || lock_n.date_lk);
    clr    = rd_ss_i || rd_tm_i || rd_dt_i || (flag_wr_i && !flag_wdata_i);
    flag_n = flag_next(flag_o, bypass_i, load_o, quiet, clr);
    ld_tm  = load_o && !lock_n.time_lk;
    ld_dt  = load_o && !lock_n.date_lk;
    ss_n   = hold_i[SS_W-1:0];
    tm_n   = hold_i[SS_W +: TM_W];
    dt_n   = hold_i[SS_W+TM_W +: DT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o  <= 1'b0;
      lock_o <= '0;
      flag_o <= 1'b0;
    end else begin
      ack_o  <= req_i;
      lock_o <= lock_n;
      flag_o <= flag_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_ss_o <= '0;
    else if (load_o) sh_ss_o <= ss_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_tm_o <= '0;
    else if (ld_tm) sh_tm_o <= tm_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_dt_o <= '0;
    else if (ld_dt) sh_dt_o <= dt_n;
  end
endmodule

// File: rtl/cal_shadow_unit.sv
module cal_shadow_unit
  import cal_shadow_pkg::*;
#(
  parameter int SS_W       = 16,
  parameter int TM_W       = 24,
  parameter int DT_W       = 24,
  parameter int RESYNC_DIV = 2,
  parameter int SYNC_STG   = 2
) (
  input  logic            rtc_clk,
  input  logic            bus_clk,
  input  logic            rst_n,
  input  logic [SS_W-1:0] live_subsec,
  input  logic [TM_W-1:0] live_time,
  input  logic [DT_W-1:0] live_date,
  input  logic            rd_subsec,
  input  logic            rd_time,
  input  logic            rd_date,
  input  logic            bypass_en,
  input  logic            flag_wr,
  input  logic            flag_wdata,
  output logic [SS_W-1:0] subsec_data,
  output logic [TM_W-1:0] time_data,
  output logic [DT_W-1:0] date_data,
  output logic            upd_flag
);
  localparam int HOLD_W = SS_W + TM_W + DT_W;

  logic              rtc_rst_n, bus_rst_n;
  logic              req_q, req_bus, ack_q, ack_rtc;
  logic [HOLD_W-1:0] live_w, hold_w;
  logic [SS_W-1:0]   sh_ss;
  logic [TM_W-1:0]   sh_tm;
  logic [DT_W-1:0]   sh_dt;
  lock_t             lock_w;
  logic              load_w;

  assign live_w = {live_date, live_time, live_subsec};

  cal_rst_sync #(.STAGES(SYNC_STG)) u_rst_rtc (
    .clk(rtc_clk), .arst_n(rst_n), .rst_n_o(rtc_rst_n));
  cal_rst_sync #(.STAGES(SYNC_STG)) u_rst_bus (
    .clk(bus_clk), .arst_n(rst_n), .rst_n_o(bus_rst_n));

  cal_rtc_side #(.HW(HOLD_W), .DIV(RESYNC_DIV)) u_rtc (
    .clk(rtc_clk), .rst_n(rtc_rst_n), .live_i(live_w), .ack_i(ack_rtc),
    .req_o(req_q), .hold_o(hold_w));

  cal_bit_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d_i(req_q), .q_o(req_bus));
  cal_bit_sync #(.STAGES(SYNC_STG)) u_ack_sync (
    .clk(rtc_clk), .rst_n(rtc_rst_n), .d_i(ack_q), .q_o(ack_rtc));

  cal_bus_side #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W)) u_bus (
    .clk(bus_clk), .rst_n(bus_rst_n), .req_i(req_bus), .hold_i(hold_w),
    .rd_ss_i(rd_subsec), .rd_tm_i(rd_time), .rd_dt_i(rd_date),
    .bypass_i(bypass_en), .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
    .ack_o(ack_q), .sh_ss_o(sh_ss), .sh_tm_o(sh_tm), .sh_dt_o(sh_dt),
    .flag_o(upd_flag), .lock_o(lock_w), .load_o(load_w));

  always_comb begin
    subsec_data = bypass_en ? live_subsec : sh_ss;
    time_data   = bypass_en ? live_time   : sh_tm;
    date_data   = bypass_en ? live_date   : sh_dt;
  end
endmodule

// File: rtl/cal_shadow_chk.sv
module cal_shadow_chk #(
  parameter int HW   = 8,
  parameter int TM_W = 4,
  parameter int DT_W = 4
) (
  input logic            rtc_clk,
  input logic            bus_clk,
  input logic            rtc_rst_n,
  input logic            bus_rst_n,
  input logic            req_q,
  input logic            ack_rtc,
  input logic [HW-1:0]   hold_w,
  input logic            rd_subsec,
  input logic            rd_time,
  input logic            rd_date,
  input logic            bypass_en,
  input logic            flag_wr,
  input logic            flag_wdata,
  input logic            upd_flag,
  input logic            lock_time,
  input logic            lock_date,
  input logic [TM_W-1:0] sh_tm,
  input logic [DT_W-1:0] sh_dt,
  input logic            load_w
);
  // R8: captured set is held while its transfer is pending
  p_hold_stable_r8: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (req_q != ack_rtc) |=> $stable(hold_w));

  // R4: frozen time shadow does not move
  p_time_frozen_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (lock_time && !rd_date) |=> $stable(sh_tm));

  // R4: frozen date shadow does not move
  p_date_frozen_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (lock_date && !rd_date) |=> $stable(sh_dt));

  // R10: date read releases every freeze
  p_release_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    rd_date |=> (!lock_time && !lock_date));

  // R5: bypass holds the flag low
  p_bypass_flag_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    bypass_en |=> !upd_flag);

  // R9: no flag rise while a freeze is held
  p_no_rise_locked_r9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    ((lock_time || lock_date) && !rd_date) |=> !$rose(upd_flag));

  // R6: read clears the flag when no refresh lands
  p_read_clear_r6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    ((rd_subsec || rd_time || rd_date) && !load_w) |=> !upd_flag);

  // R7: writing zero clears the flag when no refresh lands
  p_write_zero_r7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (flag_wr && !flag_wdata && !load_w) |=> !upd_flag);

  // R3: flag is low while the bus domain is in reset
  p_reset_low_r3: assert property (@(posedge bus_clk)
    !bus_rst_n |-> !upd_flag);
endmodule

bind cal_shadow_unit cal_shadow_chk #(.HW(HOLD_W), .TM_W(TM_W), .DT_W(DT_W)) u_chk (
  .rtc_clk(rtc_clk), .bus_clk(bus_clk), .rtc_rst_n(rtc_rst_n),
  .bus_rst_n(bus_rst_n), .req_q(req_q), .ack_rtc(ack_rtc), .hold_w(hold_w),
  .rd_subsec(rd_subsec), .rd_time(rd_time), .rd_date(rd_date),
  .bypass_en(bypass_en), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
  .upd_flag(upd_flag), .lock_time(lock_w.time_lk), .lock_date(lock_w.date_lk),
  .sh_tm(sh_tm), .sh_dt(sh_dt), .load_w(load_w));

// File: tb/sim_cal_shadow_unit.sv
module sim_cal_shadow_unit;
  localparam int BUS_PERIOD = 10;
  localparam int RTC_HALF   = 13;
  localparam int SS_W = 4;
  localparam int TM_W = 6;
  localparam int DT_W = 5;
  localparam int SETTLE = 40;

  logic rtc_clk, bus_clk, rst_n, rtc_run;
  logic [SS_W-1:0] live_subsec;
  logic [TM_W-1:0] live_time;
  logic [DT_W-1:0] live_date;
  logic rd_subsec, rd_time, rd_date, bypass_en, flag_wr, flag_wdata;
  logic [SS_W-1:0] subsec_data;
  logic [TM_W-1:0] time_data;
  logic [DT_W-1:0] date_data;
  logic upd_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  cal_shadow_unit #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W),
                    .RESYNC_DIV(2), .SYNC_STG(2)) u0 (
    .rtc_clk(rtc_clk), .bus_clk(bus_clk), .rst_n(rst_n),
    .live_subsec(live_subsec), .live_time(live_time), .live_date(live_date),
    .rd_subsec(rd_subsec), .rd_time(rd_time), .rd_date(rd_date),
    .bypass_en(bypass_en), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .subsec_data(subsec_data), .time_data(time_data), .date_data(date_data),
    .upd_flag(upd_flag));

  initial bus_clk = 1'b0;
  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;

  initial rtc_clk = 1'b0;
  always begin
    #(RTC_HALF);
    if (rtc_run) rtc_clk = ~rtc_clk;
  end

  function automatic int ss_of(int v); return v % 16; endfunction
  function automatic int tm_of(int v); return (v * 7 + 1) % 64; endfunction
  function automatic int dt_of(int v); return (v * 3 + 2) % 32; endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic set_live(int v);
    live_subsec = SS_W'(ss_of(v));
    live_time   = TM_W'(tm_of(v));
    live_date   = DT_W'(dt_of(v));
  endtask

  task automatic rd(bit s, bit t, bit d);
    rd_subsec = s; rd_time = t; rd_date = d;
    @(negedge bus_clk);
    rd_subsec = 0; rd_time = 0; rd_date = 0;
  endtask

  task automatic wr_flag(bit val);
    flag_wr = 1; flag_wdata = val;
    @(negedge bus_clk);
    flag_wr = 0; flag_wdata = 0;
  endtask

  task automatic wait_flag(output int n);
    n = 0;
    while (!upd_flag && n < 60) begin
      @(negedge bus_clk);
      n++;
    end
  endtask

  task automatic chk_all(string req, int v);
    chk(req, int'(subsec_data), ss_of(v));
    chk(req, int'(time_data), tm_of(v));
    chk(req, int'(date_data), dt_of(v));
  endtask

  initial begin
    int n;
    rst_n = 1; rtc_run = 1;
    rd_subsec = 0; rd_time = 0; rd_date = 0;
    bypass_en = 0; flag_wr = 0; flag_wdata = 0;
    set_live(9);
    #2 rst_n = 0;
    cyc(5);
    // R3: reset state in shadow mode
    chk("R3", int'(subsec_data), 0);
    chk("R3", int'(time_data), 0);
    chk("R3", int'(date_data), 0);
    chk("R3", int'(upd_flag), 0);
    rst_n = 1;

    // R1/R8: sweep of every subsecond code, fields tied arithmetically
    for (int v = 0; v < 16; v++) begin
      set_live(v);
      cyc(SETTLE);
      chk("R1", int'(subsec_data), ss_of(v));
      chk("R1", int'(time_data), tm_of(v));
      chk("R8", int'(date_data), dt_of(v));
    end

    // R2: flag sets, and sets again after a clearing read
    wait_flag(n);
    chk("R2", int'(upd_flag), 1);
    rd(0, 0, 1);
    wait_flag(n);
    chk("R2", int'(n < 60), 1);

    // R7: write of one ignored, write of zero clears (RTC clock stopped)
    wait_flag(n);
    rtc_run = 0;
    cyc(6);
    chk("R2", int'(upd_flag), 1);
    wr_flag(1);
    chk("R7", int'(upd_flag), 1);
    wr_flag(0);
    chk("R7", int'(upd_flag), 0);
    rtc_run = 1;

    // R6: read clears the flag (RTC clock stopped)
    wait_flag(n);
    rtc_run = 0;
    cyc(6);
    rd(0, 0, 1);
    chk("R6", int'(upd_flag), 0);
    rtc_run = 1;

    // R4/R9/R10: subsecond read freezes time and date
    set_live(3);
    cyc(SETTLE);
    rd(1, 0, 0);
    chk("R9", int'(upd_flag), 0);
    set_live(10);
    cyc(SETTLE);
    chk("R4", int'(subsec_data), ss_of(10));
    chk("R4", int'(time_data), tm_of(3));
    chk("R4", int'(date_data), dt_of(3));
    chk("R9", int'(upd_flag), 0);
    rd(0, 1, 0);
    cyc(SETTLE);
    chk("R4", int'(time_data), tm_of(3));
    chk("R4", int'(date_data), dt_of(3));
    rd(0, 0, 1);
    cyc(SETTLE);
    chk_all("R10", 10);
    wait_flag(n);
    chk("R2", int'(upd_flag), 1);

    // R4: time read freezes only the date
    set_live(5);
    cyc(SETTLE);
    rd(0, 1, 0);
    set_live(12);
    cyc(SETTLE);
    chk("R4", int'(subsec_data), ss_of(12));
    chk("R4", int'(time_data), tm_of(12));
    chk("R4", int'(date_data), dt_of(5));
    rd(0, 0, 1);
    cyc(SETTLE);
    chk("R10", int'(date_data), dt_of(12));

    // R10: date read in the same cycle as subsecond read wins
    rd(1, 0, 1);
    set_live(7);
    cyc(SETTLE);
    chk_all("R10", 7);

    // R5: bypass returns live words, flag held low
    bypass_en = 1;
    #1;
    chk_all("R5", 7);
    set_live(14);
    #1;
    chk_all("R5", 14);
    cyc(1);
    chk("R5", int'(upd_flag), 0);

    // R11: reads under bypass set no freeze
    rd(1, 0, 0);
    bypass_en = 0;
    set_live(2);
    cyc(SETTLE);
    chk("R11", int'(time_data), tm_of(2));
    chk("R11", int'(date_data), dt_of(2));

    // R3/R1: reset mid-run, then recovery
    rst_n = 0;
    cyc(2);
    chk("R3", int'(time_data), 0);
    chk("R3", int'(upd_flag), 0);
    rst_n = 1;
    cyc(SETTLE);
    chk_all("R1", 2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge bus_clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule